// File: doc/BRIEF.md
# Two-Wire Bias DAC Command Sender

This block pushes one fixed-format command to an external bias-voltage DAC over a two-wire serial link that can only be written. The serial clock and data lines are not pins of their own. They are two bit fields of a power-control register that other logic shares. Every line change therefore goes out as a full register write: the caller's current register value, with only the clock and data fields replaced.

A one-cycle `start` pulse launches the command. The block captures the data byte and the register base value. It then emits a start condition, three bytes, and a stop condition. The three bytes are the fixed device address 0x9C, the fixed control byte 0x00 and the caller's byte. A blind acknowledge clock follows each byte, and the DAC's answer is never looked at. Writes are spaced by a hold interval derived from the system clock frequency, which meets the DAC's minimum 10 µs gap. A one-cycle `done` pulse closes the transaction.

Top module: `dac_cmd_sender`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `reg_wr` and `done` are 0.
- R2: In every write, all bits of `reg_wdata` other than the clock field (bit 0) and the data field (bit 1) equal `base_in` as sampled on the accepting `start` cycle.
- R3: The first three writes carry (clock, data) = (1,1), then (1,0), then (0,0).
- R4: Each data bit takes three writes: the data level with clock 0, the same level with clock 1, and the same level with clock 0. Bits go most significant first.
- R5: After every eighth bit comes an acknowledge slot of three writes with data 0 and clock 0, 1, 0. No input is sampled for it.
- R6: The bytes sent, in order, are 0x9C, 0x00 and `data_in` as sampled on the accepting `start` cycle.
- R7: The last three writes carry (clock, data) = (0,0), then (1,0), then (1,1). A transaction is exactly 87 writes.
- R8: The first write is strobed in the cycle after `start` is accepted. Successive writes are exactly GAP cycles apart, where GAP = CLK_KHZ·GAP_NS/10^6 (at least 1).
- R9: A `start` pulse that arrives while a transaction is in progress is ignored. It changes no write and no timing.
- R10: `done` is high for exactly one cycle, GAP cycles after the final write, and never in the same cycle as `reg_wr`. A new `start` is accepted from the cycle after `done`.
- R11: Between two consecutive writes, at most one of the two line fields changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction; ignored while busy |
| data_in | input | 8 | Byte sent third, sampled with `start` |
| base_in | input | 8 | Current value of the shared register, sampled with `start` |
| reg_wdata | output | 8 | Value to write into the shared register |
| reg_wr | output | 1 | One-cycle write strobe for `reg_wdata` |
| done | output | 1 | One-cycle pulse when the transaction ends |

## Verification
The assertions assume that whoever owns the shared register leaves `base_in` alone while a command is running. They also assume that `start` is a plain synchronous level, and that nothing but this block moves the clock and data fields. The stimulus keeps `base_in` and `data_in` fixed from the accepting `start` until `done`, except during the deliberate ignored-start pulses, which also present a different `data_in`. It drives every input on the falling clock edge. It covers all-ones and all-zeros payloads, alternating bit patterns, several base values in the shared bits, a start held high while busy, and a start issued in the cycle right after `done`.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    // Which part of the transaction the sequencer is in.
    typedef enum logic [1:0] {
        SEG_START = 2'd0,
        SEG_BITS  = 2'd1,
        SEG_STOP  = 2'd2
    } seg_e;

    // Levels of the two serial lines for one register write.
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    // Line levels for a given segment, step within it, and payload bit.
    function automatic lines_t seg_lines(input seg_e seg, input logic [1:0] ph,
                                         input logic is_ack, input logic bitv);
        lines_t r;
        r = '{scl: 1'b1, sda: 1'b1};
        unique case (seg)
            SEG_START: begin
                r.scl = (ph != 2'd2);
                r.sda = (ph == 2'd0);
            end
            SEG_STOP: begin
                r.scl = (ph != 2'd0);
                r.sda = (ph == 2'd2);
            end
            SEG_BITS: begin
                r.scl = (ph == 2'd1);
                r.sda = is_ack ? 1'b0 : bitv;
            end
            default: r = '{scl: 1'b1, sda: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dac_gap_timer.sv
module dac_gap_timer #(
    parameter int GAP = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (GAP > 1) ? $clog2(GAP + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(GAP - 1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
    import dac_cmd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     adv,
    input  logic [NBYTES*BYTE_W-1:0] payload,
    output lines_t                   lines,
    output logic                     last
);
    localparam int SH_W  = NBYTES * BYTE_W;
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam int CNT_W = $clog2(NBYTES + 1);

    seg_e             seg;
    logic [1:0]       ph;
    logic [BIT_W-1:0] bitn;
    logic [CNT_W-1:0] byten;
    logic [SH_W-1:0]  sh;
    logic             at_ack;

    assign at_ack = (bitn == BIT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            seg   <= SEG_START;
            ph    <= 2'd0;
            bitn  <= '0;
            byten <= '0;
            sh    <= '0;
        end else if (load) begin
            // step 0 of the start condition is written in this same cycle
            seg   <= SEG_START;
            ph    <= 2'd1;
            bitn  <= '0;
            byten <= '0;
            sh    <= payload;
        end else if (adv) begin
            if (ph != 2'd2) begin
                ph <= ph + 2'd1;
            end else begin
                ph <= 2'd0;
                unique case (seg)
                    SEG_START: seg <= SEG_BITS;
                    SEG_BITS: begin
                        if (at_ack) begin
                            bitn <= '0;
                            if (byten == CNT_W'(NBYTES - 1)) begin
                                seg   <= SEG_STOP;
                                byten <= '0;
                            end else begin
                                byten <= byten + CNT_W'(1);
                            end
                        end else begin
                            bitn <= bitn + BIT_W'(1);
                            sh   <= {sh[SH_W-2:0], 1'b0};
                        end
                    end
                    SEG_STOP: seg <= SEG_START;
                    default:  seg <= SEG_START;
                endcase
            end
        end
    end

    assign lines = seg_lines(seg, ph, at_ack, sh[SH_W-1]);
    assign last  = (seg == SEG_STOP) && (ph == 2'd2);

endmodule

// File: rtl/dac_cmd_sender.sv
module dac_cmd_sender
    import dac_cmd_pkg::*;
#(
    parameter int          REG_W     = 8,
    parameter int          BYTE_W    = 8,
    parameter int          CLK_POS   = 0,
    parameter int          DAT_POS   = 1,
    parameter logic [7:0]  ADDR_BYTE = 8'h9C,
    parameter logic [7:0]  CTRL_BYTE = 8'h00,
    parameter int          CLK_KHZ   = 100000,
    parameter int          GAP_NS    = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [REG_W-1:0] base_in,
    output logic [REG_W-1:0] reg_wdata,
    output logic             reg_wr,
    output logic             done
);
    localparam int NBYTES  = 3;
    localparam int GAP_RAW = (CLK_KHZ * GAP_NS) / 1000000;
    localparam int GAP     = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int GW      = $clog2(GAP + 2);

    logic             busy;
    logic             last_sent;
    logic [REG_W-1:0] base_q;
    logic             accept, issue, finish, expired, seq_last;
    lines_t           lines;
    logic [REG_W-1:0] base_sel, next_word;

    assign accept = start && !busy;
    assign issue  = accept || (busy && expired && !last_sent);
    assign finish = busy && expired && last_sent;

    dac_gap_timer #(.GAP(GAP)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (issue),
        .expired (expired)
    );

    dac_cmd_seq #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .adv     (issue),
        .payload ({BYTE_W'(ADDR_BYTE), BYTE_W'(CTRL_BYTE), data_in}),
        .lines   (lines),
        .last    (seq_last)
    );

    assign base_sel = accept ? base_in : base_q;

    always_comb begin
        next_word          = base_sel;
        next_word[CLK_POS] = lines.scl;
        next_word[DAT_POS] = lines.sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            last_sent <= 1'b0;
            base_q    <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            done      <= 1'b0;
        end else begin
            reg_wr <= issue;
            done   <= finish;
            if (accept) begin
                busy   <= 1'b1;
                base_q <= base_in;
            end else if (finish) begin
                busy <= 1'b0;
            end
            if (issue) begin
                reg_wdata <= next_word;
                last_sent <= accept ? 1'b0 : seq_last;
            end
        end
    end

    // ---- checks next to the logic ----
    logic          prev_scl, prev_sda;
    logic [GW-1:0] since_wr;
    logic [REG_W-1:0] keep_mask;

    always_comb begin
        keep_mask          = '1;
        keep_mask[CLK_POS] = 1'b0;
        keep_mask[DAT_POS] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
            since_wr <= GW'(GAP);
        end else begin
            if (reg_wr) begin
                prev_scl <= reg_wdata[CLK_POS];
                prev_sda <= reg_wdata[DAT_POS];
                since_wr <= GW'(1);
            end else if (since_wr < GW'(GAP)) begin
                since_wr <= since_wr + GW'(1);
            end
        end
    end

    p_one_line_r11: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $countones({reg_wdata[CLK_POS] ^ prev_scl,
                               reg_wdata[DAT_POS] ^ prev_sda}) <= 1);

    p_gap_r8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> since_wr >= GW'(GAP));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_no_wr_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, reg_wr}));

    p_keep_bits_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> ((reg_wdata & keep_mask) == (base_q & keep_mask)));

    p_wr_in_txn_r9: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> busy);

endmodule

// File: tb/test_dac_cmd_sender.sv
module test_dac_cmd_sender;
    localparam int GAP = 4;   // 200000 kHz * 20 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] base_in = 8'h00;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       done;

    always #2.5 clk = ~clk;

    dac_cmd_sender #(.CLK_KHZ(200000), .GAP_NS(20)) i_dac_cmd_sender (
        .clk(clk), .rst(rst), .start(start), .data_in(data_in),
        .base_in(base_in), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] exp_q[$];
    int         idx_q[$];
    bit         m_busy;
    int         m_cnt;
    bit         e_wr, e_done;
    logic [7:0] e_wd;
    int         e_idx;

    function automatic void push_w(input logic [7:0] b, input bit c, input bit s);
        logic [7:0] w;
        w = b;
        w[0] = c;
        w[1] = s;
        idx_q.push_back(exp_q.size());
        exp_q.push_back(w);
    endfunction

    function automatic void build(input logic [7:0] b, input logic [7:0] d);
        logic [7:0] bytes[3];
        exp_q.delete();
        idx_q.delete();
        bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = d;
        push_w(b, 1, 1); push_w(b, 1, 0); push_w(b, 0, 0);
        for (int k = 0; k < 3; k++) begin
            for (int j = 7; j >= 0; j--) begin
                push_w(b, 0, bytes[k][j]);
                push_w(b, 1, bytes[k][j]);
                push_w(b, 0, bytes[k][j]);
            end
            push_w(b, 0, 0); push_w(b, 1, 0); push_w(b, 0, 0);
        end
        push_w(b, 0, 0); push_w(b, 1, 0); push_w(b, 1, 1);
    endfunction

    function automatic void pop_w();
        e_wr  = 1;
        e_wd  = exp_q.pop_front();
        e_idx = idx_q.pop_front();
        m_cnt = GAP - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; e_wr = 0; e_done = 0; e_wd = 0; e_idx = 0;
        end else begin
            e_wr = 0;
            e_done = 0;
            if (!m_busy) begin
                if (start) begin
                    build(base_in, data_in);
                    m_busy = 1;
                    pop_w();
                end
            end else if (m_cnt > 0) begin
                m_cnt--;
            end else if (exp_q.size() > 0) begin
                pop_w();
            end else begin
                e_done = 1;
                m_busy = 0;
            end
        end
    end

    function automatic string line_tag(input int i);
        int slot;
        if (i < 3) return "R3";
        if (i >= 84) return "R7";
        slot = (i - 3) / 3;
        if (slot % 9 == 8) return "R5";
        return "R4";
    endfunction

    // ---------------- per-cycle comparison ----------------
    logic [7:0] got_q[$];

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(reg_wr == e_wr, "R8", "write strobe timing", reg_wr, e_wr);
            chk(done == e_done, "R10", "done pulse", done, e_done);
            if (e_wr && reg_wr) begin
                chk((reg_wdata & 8'hFC) == (e_wd & 8'hFC), "R2", "shared bits",
                    reg_wdata, e_wd);
                chk(reg_wdata[1:0] == e_wd[1:0], line_tag(e_idx), "line levels",
                    reg_wdata[1:0], e_wd[1:0]);
            end
            if (reg_wr) got_q.push_back(reg_wdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 2000);
        chk(done, "R10", "done seen", done, 1);
    endtask

    task automatic decode(input logic [7:0] d);
        logic [7:0] got[3];
        chk(got_q.size() == 87, "R7", "write count", got_q.size(), 87);
        if (got_q.size() == 87) begin
            for (int slot = 0; slot < 27; slot++) begin
                logic [7:0] w;
                w = got_q[3 + slot * 3 + 1];
                if (slot % 9 == 8)
                    chk(w[1] == 1'b0, "R5", "ack data low", w[1], 0);
                else
                    got[slot / 9][7 - (slot % 9)] = w[1];
            end
            chk(got[0] == 8'h9C, "R6", "first byte", got[0], 8'h9C);
            chk(got[1] == 8'h00, "R6", "second byte", got[1], 8'h00);
            chk(got[2] == d, "R6", "third byte", got[2], d);
        end
    endtask

    task automatic run_txn(input logic [7:0] b, input logic [7:0] d, input bit poke);
        got_q.delete();
        @(negedge clk);
        base_in = b; data_in = d; start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            // R9: start pulses and a held start while busy are ignored
            repeat (10) @(negedge clk);
            start = 1; data_in = ~d;
            @(negedge clk);
            start = 0;
            repeat (40) @(negedge clk);
            start = 1;
            repeat (15) @(negedge clk);
            start = 0; data_in = d;
        end
        wait_done();
        decode(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(reg_wr == 0, "R1", "reg_wr in reset", reg_wr, 0);
        chk(done == 0, "R1", "done in reset", done, 0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(reg_wr == 0, "R1", "reg_wr after reset", reg_wr, 0);
        chk(done == 0, "R1", "done after reset", done, 0);

        run_txn(8'h00, 8'hA5, 0);
        run_txn(8'hFC, 8'hFF, 0);
        run_txn(8'hE0, 8'h00, 1);     // R9
        // back-to-back: start in the cycle right after done (R10)
        got_q.delete();
        base_in = 8'h5A; data_in = 8'h7E; start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
        decode(8'h7E);
        run_txn(8'h80, 8'h01, 0);
        repeat (10) @(negedge clk);
        chk(reg_wr == 0 && done == 0, "R10", "idle after done", {reg_wr, done}, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule